// File: doc/BRIEF.md
# Address-Event Splitter/Merger Switch

This block moves address events between one primary port and a set of secondary ports (four by default). Every port uses a four-phase request/acknowledge handshake: the sender raises its request with the address held steady, the receiver raises acknowledge, the sender lowers request, and the receiver lowers acknowledge. All handshake inputs are taken to be synchronous to `clk`.

One static configuration bit selects the direction of traffic.

In fan-out (splitter) mode, events arrive on the primary input and leave on the secondary outputs. A second bit picks between two sub-modes:
- **Copy:** every event goes to every enabled output.
- **Window:** each output owns an inclusive address window, and the event goes to the first enabled output whose window contains it.

In fan-in (merger) mode, events from the enabled secondary inputs are serialised by a round-robin arbiter onto the primary output. A channel number can optionally be placed above the address so that the consumer knows which input each event came from.

The switch handles one event at a time. The source is acknowledged only after every destination has finished its own handshake. As a result, back-pressure from a slow receiver propagates straight to the sender.

Top module: `aer_route_switch`

## Requirements
- R1: In copy sub-mode (`cfg_merge`=0, `cfg_window`=0), an event accepted on the primary input is presented once, with the same 16-bit address, on every secondary output whose `cfg_en` bit is 1. Outputs whose bit is 0 never raise a request.
- R2: In copy sub-mode, `pri_in_ack` rises only after every enabled secondary output has seen both its request and its acknowledge return low. A stalled receiver keeps the primary acknowledge low.
- R3: In window sub-mode (`cfg_window`=1), output i (bits `[16*i+15:16*i]` of `cfg_lo`/`cfg_hi`) matches when `cfg_en[i]`=1 and lo ≤ address ≤ hi. The event goes only to the lowest-numbered matching output, so at most one output request is high at a time.
- R4: An event with no destination is still acknowledged on the primary input, and no secondary request is raised. This covers an event that matches no window, and an event arriving in copy sub-mode with `cfg_en`=0.
- R5: In merger mode (`cfg_merge`=1), each request on an enabled secondary input produces exactly one primary-output event. The input's acknowledge rises only after the primary output handshake has fully completed. Inputs whose `cfg_en` bit is 0 are never acknowledged or forwarded.
- R6: The merger grants in round-robin order. After reset the search starts at input 0, and after a grant to input k it starts at input k+1, wrapping to 0. With all four requesting, the grant order is 0, 1, 2, 3.
- R7: `pri_out_data` is 18 bits with the address in bits `[15:0]`. When `cfg_tag`=1, bits `[17:16]` hold the granted input number. When `cfg_tag`=0, those bits are 0.
- R8: Every request the block drives stays high, with its data unchanged, until the matching acknowledge is seen.
- R9: After reset, every request and acknowledge output is low.
- R10: In splitter mode, no secondary input is acknowledged and the primary output stays idle. In merger mode, the primary input is never acknowledged and no secondary output request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_merge | input | 1 | 1 = merger mode, 0 = splitter mode |
| cfg_window | input | 1 | Splitter sub-mode: 1 = window routing, 0 = copy |
| cfg_tag | input | 1 | Merger: place channel number in upper output bits |
| cfg_en | input | 4 | Per-channel enable (outputs in splitter mode, inputs in merger mode) |
| cfg_lo | input | 64 | Inclusive window low bound per output, 16 bits each |
| cfg_hi | input | 64 | Inclusive window high bound per output, 16 bits each |
| pri_in_req | input | 1 | Primary input request |
| pri_in_addr | input | 16 | Primary input address |
| pri_in_ack | output | 1 | Primary input acknowledge |
| pri_out_req | output | 1 | Primary output request |
| pri_out_data | output | 18 | Primary output word (tag and address) |
| pri_out_ack | input | 1 | Primary output acknowledge |
| sec_out_req | output | 4 | Secondary output requests |
| sec_out_addr | output | 64 | Secondary output addresses, 16 bits per lane |
| sec_out_ack | input | 4 | Secondary output acknowledges |
| sec_in_req | input | 4 | Secondary input requests |
| sec_in_addr | input | 64 | Secondary input addresses, 16 bits per lane |
| sec_in_ack | output | 4 | Secondary input acknowledges |

## Verification
Several protocol properties are checked by assertions on every cycle:
- Each driven request is held, with steady data, until it is acknowledged.
- In window sub-mode, at most one lane requests at a time.
- In copy sub-mode, the primary acknowledge never rises while an enabled lane is still mid-handshake.
- At most one merger input is acknowledged, and only while the primary output is idle.
- The inactive half of the switch stays quiet.

Some behaviours can only be shown by the bench scenarios:
- which lane receives a given address (first match, inclusive bounds, no match);
- the round-robin grant sequence;
- the tag contents;
- that disabled channels are ignored.

// File: rtl/aerx_pkg.sv
package aerx_pkg;

   typedef enum logic [1:0] {
      SP_IDLE,
      SP_SEND,
      SP_ACK
   } split_st_t;

   typedef enum logic [1:0] {
      MG_IDLE,
      MG_XFER,
      MG_DRAIN,
      MG_REL
   } merge_st_t;

endpackage

// File: rtl/aer_rr_pick.sv
module aer_rr_pick #(
   parameter int NCH   = 4,
   parameter int TAG_W = 2
) (
   input  logic [NCH-1:0]   req,
   input  logic [TAG_W-1:0] ptr,
   output logic             any,
   output logic [TAG_W-1:0] idx
);

   // Scan from the pointer upward, wrapping once; the first requester wins.
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = 0; k < NCH; k++) begin
         int c;
         c = int'(ptr) + k;
         if (c >= NCH) c = c - NCH;
         if (!any && req[c]) begin
            any = 1'b1;
            idx = TAG_W'(c);
         end
      end
   end

endmodule

// File: rtl/aer_split_fan.sv
module aer_split_fan
   import aerx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NCH    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              cfg_window,
   input  logic [NCH-1:0]    cfg_en,
   input  logic [NCH*ADDR_W-1:0] cfg_lo,
   input  logic [NCH*ADDR_W-1:0] cfg_hi,
   input  logic              in_req,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              in_ack,
   output logic [NCH-1:0]    out_req,
   output logic [ADDR_W-1:0] out_addr,
   input  logic [NCH-1:0]    out_ack
);

   split_st_t         st_q;
   logic [NCH-1:0]    hit, first, target;
   logic [NCH-1:0]    want_q, req_q, seen_q, done_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ack_q;

   // One inclusive window comparator per lane
   for (genvar g = 0; g < NCH; g++) begin : g_win
      assign hit[g] = cfg_en[g] &&
                      (in_addr >= cfg_lo[g*ADDR_W +: ADDR_W]) &&
                      (in_addr <= cfg_hi[g*ADDR_W +: ADDR_W]);
   end

   // Lowest-numbered matching lane wins
   always_comb begin
      logic found;
      found = 1'b0;
      first = '0;
      for (int i = 0; i < NCH; i++) begin
         if (hit[i] && !found) begin
            first[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign target = cfg_window ? first : cfg_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SP_IDLE;
         want_q <= '0;
         req_q  <= '0;
         seen_q <= '0;
         done_q <= '0;
         addr_q <= '0;
         ack_q  <= 1'b0;
      end else begin
         case (st_q)
            SP_IDLE: begin
               if (active && in_req) begin
                  addr_q <= in_addr;
                  want_q <= target;
                  req_q  <= target;
                  seen_q <= '0;
                  done_q <= '0;
                  if (target == '0) begin
                     ack_q <= 1'b1;
                     st_q  <= SP_ACK;
                  end else begin
                     st_q  <= SP_SEND;
                  end
               end
            end
            SP_SEND: begin
               for (int i = 0; i < NCH; i++) begin
                  if (req_q[i] && out_ack[i]) begin
                     req_q[i]  <= 1'b0;
                     seen_q[i] <= 1'b1;
                  end
                  if (seen_q[i] && !out_ack[i]) done_q[i] <= 1'b1;
               end
               if (done_q == want_q) begin
                  ack_q <= 1'b1;
                  st_q  <= SP_ACK;
               end
            end
            SP_ACK: begin
               if (!in_req) begin
                  ack_q <= 1'b0;
                  st_q  <= SP_IDLE;
               end
            end
            default: st_q <= SP_IDLE;
         endcase
      end
   end

   assign in_ack   = ack_q;
   assign out_req  = req_q;
   assign out_addr = addr_q;

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      // R8
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_req[g] && !out_ack[g]) |=> out_req[g]);
   end

   // R8
   lane_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_req) |=> $stable(out_addr));

   // R3
   window_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_window |-> $onehot0(out_req));

   // R2
   copy_ack_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_window && $rose(in_ack)) |-> (((out_req | out_ack) & cfg_en) == '0));

endmodule

// File: rtl/aer_merge_fan.sv
module aer_merge_fan
   import aerx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NCH    = 4,
   parameter int TAG_W  = 2,
   parameter int OUT_W  = ADDR_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              cfg_tag,
   input  logic [NCH-1:0]    cfg_en,
   input  logic [NCH-1:0]    in_req,
   input  logic [NCH*ADDR_W-1:0] in_addr,
   output logic [NCH-1:0]    in_ack,
   output logic              out_req,
   output logic [OUT_W-1:0]  out_data,
   input  logic              out_ack
);

   merge_st_t         st_q;
   logic [TAG_W-1:0]  ptr_q, idx_q, pick;
   logic              any;
   logic [OUT_W-1:0]  data_q;
   logic              oreq_q;
   logic [NCH-1:0]    iack_q;
   logic [ADDR_W-1:0] sel_addr;

   aer_rr_pick #(.NCH(NCH), .TAG_W(TAG_W)) u_pick (
      .req (in_req & cfg_en),
      .ptr (ptr_q),
      .any (any),
      .idx (pick)
   );

   assign sel_addr = in_addr[int'(pick)*ADDR_W +: ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= MG_IDLE;
         ptr_q  <= '0;
         idx_q  <= '0;
         data_q <= '0;
         oreq_q <= 1'b0;
         iack_q <= '0;
      end else begin
         case (st_q)
            MG_IDLE: begin
               if (active && any) begin
                  idx_q  <= pick;
                  data_q <= cfg_tag ? {pick, sel_addr} : {{TAG_W{1'b0}}, sel_addr};
                  oreq_q <= 1'b1;
                  st_q   <= MG_XFER;
               end
            end
            MG_XFER: begin
               if (out_ack) begin
                  oreq_q <= 1'b0;
                  st_q   <= MG_DRAIN;
               end
            end
            MG_DRAIN: begin
               if (!out_ack) begin
                  iack_q[idx_q] <= 1'b1;
                  st_q          <= MG_REL;
               end
            end
            MG_REL: begin
               if (!in_req[idx_q]) begin
                  iack_q <= '0;
                  if (int'(idx_q) == NCH - 1) ptr_q <= '0;
                  else                        ptr_q <= idx_q + 1'b1;
                  st_q <= MG_IDLE;
               end
            end
            default: st_q <= MG_IDLE;
         endcase
      end
   end

   assign in_ack   = iack_q;
   assign out_req  = oreq_q;
   assign out_data = data_q;

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && !out_ack) |=> (out_req && $stable(out_data)));

   // R5
   in_ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ack));

   // R5
   in_ack_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_ack) |-> (!out_req && !out_ack));

   // R5
   in_ack_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|in_ack) |-> ((in_ack & cfg_en) == in_ack));

endmodule

// File: rtl/aer_route_switch.sv
module aer_route_switch #(
   parameter int ADDR_W = 16,
   parameter int NCH    = 4,
   localparam int TAG_W = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int OUT_W = ADDR_W + TAG_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_merge,
   input  logic                  cfg_window,
   input  logic                  cfg_tag,
   input  logic [NCH-1:0]        cfg_en,
   input  logic [NCH*ADDR_W-1:0] cfg_lo,
   input  logic [NCH*ADDR_W-1:0] cfg_hi,
   input  logic                  pri_in_req,
   input  logic [ADDR_W-1:0]     pri_in_addr,
   output logic                  pri_in_ack,
   output logic                  pri_out_req,
   output logic [OUT_W-1:0]      pri_out_data,
   input  logic                  pri_out_ack,
   output logic [NCH-1:0]        sec_out_req,
   output logic [NCH*ADDR_W-1:0] sec_out_addr,
   input  logic [NCH-1:0]        sec_out_ack,
   input  logic [NCH-1:0]        sec_in_req,
   input  logic [NCH*ADDR_W-1:0] sec_in_addr,
   output logic [NCH-1:0]        sec_in_ack
);

   // Elaboration-time parameter checks
   if (NCH < 2 || NCH > 4) begin : g_bad_nch
      $error("aer_route_switch: NCH must be 2..4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("aer_route_switch: ADDR_W must be positive");
   end

   logic [ADDR_W-1:0] lane_addr;

   aer_split_fan #(.ADDR_W(ADDR_W), .NCH(NCH)) u_split (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (!cfg_merge),
      .cfg_window (cfg_window),
      .cfg_en     (cfg_en),
      .cfg_lo     (cfg_lo),
      .cfg_hi     (cfg_hi),
      .in_req     (pri_in_req),
      .in_addr    (pri_in_addr),
      .in_ack     (pri_in_ack),
      .out_req    (sec_out_req),
      .out_addr   (lane_addr),
      .out_ack    (sec_out_ack)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_lane
      assign sec_out_addr[g*ADDR_W +: ADDR_W] = lane_addr;
   end

   aer_merge_fan #(.ADDR_W(ADDR_W), .NCH(NCH), .TAG_W(TAG_W), .OUT_W(OUT_W)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (cfg_merge),
      .cfg_tag  (cfg_tag),
      .cfg_en   (cfg_en),
      .in_req   (sec_in_req),
      .in_addr  (sec_in_addr),
      .in_ack   (sec_in_ack),
      .out_req  (pri_out_req),
      .out_data (pri_out_data),
      .out_ack  (pri_out_ack)
   );

   // R10
   merge_quiet_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_merge |-> (!pri_in_ack && (sec_out_req == '0)));

   // R10
   split_quiet_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_merge |-> (!pri_out_req && (sec_in_ack == '0)));

endmodule

// File: tb/aer_route_switch_tb.sv
module aer_route_switch_tb_top;

   localparam int CLK_P = 10;
   localparam int AW    = 16;
   localparam int NC    = 4;
   localparam int OW    = 18;
   localparam int TMO   = 400;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_merge = 1'b0, cfg_window = 1'b0, cfg_tag = 1'b0;
   logic [NC-1:0]  cfg_en = '0;
   logic [NC*AW-1:0] cfg_lo = '0, cfg_hi = '0;
   logic           pri_in_req = 1'b0;
   logic [AW-1:0]  pri_in_addr = '0;
   logic           pri_in_ack;
   logic           pri_out_req;
   logic [OW-1:0]  pri_out_data;
   logic           pri_out_ack = 1'b0;
   logic [NC-1:0]  sec_out_req;
   logic [NC*AW-1:0] sec_out_addr;
   logic [NC-1:0]  sec_out_ack = '0;
   logic [NC-1:0]  sec_in_req = '0;
   logic [NC*AW-1:0] sec_in_addr = '0;
   logic [NC-1:0]  sec_in_ack;

   int checks = 0, fails = 0;
   logic [NC-1:0] stall = '0;
   int so_cnt [NC];
   logic [AW-1:0] so_last [NC];
   int po_cnt = 0;
   logic [OW-1:0] po_log [16];

   always #(CLK_P/2) clk = ~clk;

   aer_route_switch dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_merge(cfg_merge), .cfg_window(cfg_window), .cfg_tag(cfg_tag),
      .cfg_en(cfg_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .pri_in_req(pri_in_req), .pri_in_addr(pri_in_addr), .pri_in_ack(pri_in_ack),
      .pri_out_req(pri_out_req), .pri_out_data(pri_out_data), .pri_out_ack(pri_out_ack),
      .sec_out_req(sec_out_req), .sec_out_addr(sec_out_addr), .sec_out_ack(sec_out_ack),
      .sec_in_req(sec_in_req), .sec_in_addr(sec_in_addr), .sec_in_ack(sec_in_ack)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: sample at the falling edge, then play every responder/sender.
   task automatic step();
      @(negedge clk);
      for (int i = 0; i < NC; i++) begin
         if (sec_out_req[i] && !sec_out_ack[i] && !stall[i]) begin
            so_cnt[i]++;
            so_last[i] = sec_out_addr[i*AW +: AW];
            sec_out_ack[i] = 1'b1;
         end else if (!sec_out_req[i]) begin
            sec_out_ack[i] = 1'b0;
         end
         if (sec_in_req[i] && sec_in_ack[i]) sec_in_req[i] = 1'b0;
      end
      if (pri_out_req && !pri_out_ack) begin
         if (po_cnt < 16) po_log[po_cnt] = pri_out_data;
         po_cnt++;
         pri_out_ack = 1'b1;
      end else if (!pri_out_req) begin
         pri_out_ack = 1'b0;
      end
      if (pri_in_req && pri_in_ack) pri_in_req = 1'b0;
   endtask

   task automatic clr_logs();
      for (int i = 0; i < NC; i++) begin
         so_cnt[i] = 0;
         so_last[i] = '0;
      end
      po_cnt = 0;
   endtask

   task automatic send_pri(input logic [AW-1:0] a, input string tag);
      int n;
      n = 0;
      pri_in_addr = a;
      pri_in_req = 1'b1;
      while ((pri_in_req || pri_in_ack || sec_out_req != '0) && n < TMO) begin
         step();
         n++;
      end
      chk(n < TMO, tag, n, TMO);
   endtask

   task automatic drain_merge(input string tag);
      int n;
      n = 0;
      step();
      while ((sec_in_req & cfg_en) != '0 || sec_in_ack != '0 || pri_out_req || pri_out_ack) begin
         if (n >= TMO) break;
         step();
         n++;
      end
      chk(n < TMO, tag, n, TMO);
   endtask

   task automatic t_reset();
      step(); step();
      chk(!pri_in_ack && !pri_out_req, "R9 primary idle", {pri_in_ack, pri_out_req}, 0);
      chk(sec_out_req == '0 && sec_in_ack == '0, "R9 secondary idle", {sec_out_req, sec_in_ack}, 0);
   endtask

   task automatic t_copy();
      clr_logs();
      cfg_merge = 0; cfg_window = 0; cfg_en = 4'b1011;
      send_pri(16'h1234, "R1 copy handshake");
      for (int i = 0; i < NC; i++) begin
         if (cfg_en[i]) begin
            chk(so_cnt[i] == 1 && so_last[i] == 16'h1234, "R1 enabled lane copy", {so_cnt[i], so_last[i]}, {32'd1, 16'h1234});
         end else begin
            chk(so_cnt[i] == 0, "R1 disabled lane idle", so_cnt[i], 0);
         end
      end
   endtask

   task automatic t_stall();
      int n;
      clr_logs();
      cfg_en = 4'b1111;
      stall = 4'b0100;
      pri_in_addr = 16'h5A5A;
      pri_in_req = 1'b1;
      for (int k = 0; k < 30; k++) step();
      chk(pri_in_ack == 1'b0, "R2 ack held back by stalled lane", pri_in_ack, 0);
      chk(sec_out_req[2] == 1'b1, "R8 stalled request held", sec_out_req[2], 1);
      chk(so_cnt[0] == 1 && so_cnt[1] == 1 && so_cnt[3] == 1, "R2 other lanes served", {so_cnt[0], so_cnt[1], so_cnt[3]}, 0);
      stall = '0;
      n = 0;
      while ((pri_in_req || pri_in_ack) && n < TMO) begin step(); n++; end
      chk(n < TMO && so_cnt[2] == 1, "R2 completes after release", so_cnt[2], 1);
   endtask

   task automatic win_one(input logic [AW-1:0] a, input int exp_lane, input string tag);
      int tot;
      clr_logs();
      send_pri(a, tag);
      tot = so_cnt[0] + so_cnt[1] + so_cnt[2] + so_cnt[3];
      if (exp_lane < 0) begin
         chk(tot == 0, tag, tot, 0);
      end else begin
         chk(tot == 1 && so_cnt[exp_lane] == 1 && so_last[exp_lane] == a, tag, tot, exp_lane);
      end
   endtask

   task automatic t_window();
      cfg_window = 1; cfg_en = 4'b1111;
      cfg_lo = {16'h1000, 16'h0200, 16'h0080, 16'h0000};
      cfg_hi = {16'hFFFF, 16'h02FF, 16'h01FF, 16'h00FF};
      win_one(16'h0090, 0, "R3 overlap first match");
      win_one(16'h0100, 1, "R3 second window");
      win_one(16'h00FF, 0, "R3 inclusive high bound");
      win_one(16'h0200, 2, "R3 inclusive low bound");
      win_one(16'hFFFF, 3, "R3 top of range");
      win_one(16'h0300, -1, "R4 unmatched dropped");
      cfg_en = 4'b1110;
      win_one(16'h0090, 1, "R3 disabled lane skipped");
      cfg_window = 0; cfg_en = 4'b0000;
      win_one(16'h0042, -1, "R4 no enabled outputs");
   endtask

   task automatic t_isolate();
      clr_logs();
      cfg_merge = 0; cfg_en = 4'b1111;
      sec_in_addr[AW-1:0] = 16'h7777;
      sec_in_req = 4'b0001;
      for (int k = 0; k < 20; k++) step();
      chk(sec_in_ack == '0 && po_cnt == 0, "R10 merger idle in splitter mode", {sec_in_ack, po_cnt}, 0);
      sec_in_req = '0;
      step(); step();
      cfg_merge = 1;
      step();
      pri_in_addr = 16'h3333;
      pri_in_req = 1'b1;
      for (int k = 0; k < 20; k++) step();
      chk(!pri_in_ack && so_cnt[0] + so_cnt[1] + so_cnt[2] + so_cnt[3] == 0,
          "R10 splitter idle in merger mode", pri_in_ack, 0);
      pri_in_req = 1'b0;
      step(); step();
   endtask

   function automatic logic [AW-1:0] in_a(input int i);
      return 16'hA000 + 16'(i) * 16'h0111;
   endfunction

   task automatic load_inputs();
      for (int i = 0; i < NC; i++) sec_in_addr[i*AW +: AW] = in_a(i);
   endtask

   task automatic t_merge_all();
      clr_logs();
      cfg_merge = 1; cfg_tag = 0; cfg_en = 4'b1111;
      load_inputs();
      sec_in_req = 4'b1111;
      drain_merge("R5 merge all completes");
      chk(po_cnt == 4, "R5 one output per input", po_cnt, 4);
      for (int k = 0; k < 4; k++)
         chk(po_log[k] == {2'b00, in_a(k)}, "R6 order 0..3 untagged R7", po_log[k], {2'b00, in_a(k)});
   endtask

   task automatic t_merge_tag();
      clr_logs();
      cfg_tag = 1;
      sec_in_req = 4'b0110;
      drain_merge("R6 pair one completes");
      chk(po_cnt == 2 && po_log[0] == {2'd1, in_a(1)} && po_log[1] == {2'd2, in_a(2)},
          "R7 tagged order 1,2", po_log[0], {2'd1, in_a(1)});
      clr_logs();
      sec_in_req = 4'b0101;
      drain_merge("R6 pair two completes");
      chk(po_cnt == 2 && po_log[0] == {2'd0, in_a(0)}, "R6 wrap from 3 picks 0", po_log[0], {2'd0, in_a(0)});
      chk(po_log[1] == {2'd2, in_a(2)}, "R7 tag for input 2", po_log[1], {2'd2, in_a(2)});
   endtask

   task automatic t_merge_order();
      int n;
      clr_logs();
      cfg_tag = 0;
      sec_in_req = 4'b0010;
      n = 0;
      while (!pri_out_req && n < TMO) begin step(); n++; end
      chk(sec_in_ack == '0, "R5 no input ack before output done", sec_in_ack, 0);
      drain_merge("R5 single completes");
      chk(po_cnt == 1 && po_log[0] == {2'b00, in_a(1)}, "R5 single forwarded", po_log[0], {2'b00, in_a(1)});
   endtask

   task automatic t_merge_disabled();
      clr_logs();
      cfg_en = 4'b1101;
      sec_in_req = 4'b0110;
      for (int k = 0; k < 40; k++) step();
      chk(po_cnt == 1 && po_log[0] == {2'b00, in_a(2)}, "R5 only enabled input forwarded", po_log[0], {2'b00, in_a(2)});
      chk(sec_in_ack[1] == 1'b0 && sec_in_req[1] == 1'b1, "R5 disabled input never acked", sec_in_ack, 0);
      sec_in_req = '0;
      step(); step();
   endtask

   initial begin
      for (int i = 0; i < NC; i++) begin so_cnt[i] = 0; so_last[i] = '0; end
      step(); step();
      rst_n = 1'b1;
      t_reset();
      t_copy();
      t_stall();
      t_window();
      t_isolate();
      t_merge_all();
      t_merge_tag();
      t_merge_order();
      t_merge_disabled();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule